// File: doc/BRIEF.md
# Trace-State Access Permission Checker

This block decides what happens when software tries to reach the control state of a branch-trace recorder. Each cycle the instruction pipeline presents one request: the current privilege mode, the virtualization flag, a decoded target and the indirect-index value that goes with it. The target is one of the supervisor control register, the virtual-supervisor control register, the depth register, the status register, the indirect alias register or the trace-clear instruction. The block answers in the same cycle with exactly one of three verdicts: allowed, illegal-instruction trap or virtual-instruction trap.

The block owns one enable bit in the machine-level state-enable register and one in the hypervisor-level state-enable register. The machine bit gates every mode below machine mode. The hypervisor bit also gates guest accesses. The depth register is never reachable from a guest. Both registers can be written and read through a simple register port. Every bit except the enable bit reads as zero, and the hypervisor bit is forced to zero while the machine bit is clear.

Hardware recording of qualifying control transfers never depends on these enables. The block therefore passes the record-update qualifier straight through.

Top module: `trc_perm_gate`

## Requirements
- R1: After reset, both enable bits are 0, and a read of either register (csr_sel 0 = machine, 1 = hypervisor) returns all zeros.
- R2: A write changes only bit 54 of the selected register, and every other bit reads as 0. The write takes effect at the clock edge on which csr_we is high.
- R3: The hypervisor bit reads as 0 and cannot be set while the machine bit is 0. Writing 0 to the machine bit clears the hypervisor bit, so it stays 0 when the machine bit is set again.
- R4: A valid request in machine mode (req_priv = 3) is always allowed, whatever the enables, the target or req_virt.
- R5: With the machine bit at 0, a valid request below machine mode (req_priv 0 = user, 1 = supervisor) traps as illegal-instruction for targets 0 (supervisor control), 1 (virtual-supervisor control), 2 (depth), 3 (status) and 5 (trace-clear).
- R6: For target 4 (indirect alias), the gating rules apply only when req_isel is in 0x200..0x2FF. Outside that window the request is allowed under every enable setting.
- R7: With req_virt = 1, the mode below machine, the machine bit at 1 and the hypervisor bit at 0, targets 0, 1, 3 and 5 and an in-window target 4 trap as virtual-instruction.
- R8: With req_virt = 1, the mode below machine and the machine bit at 1, target 2 (depth) always traps as virtual-instruction, whatever the hypervisor bit holds.
- R9: With the machine bit at 1, non-virtualized requests are allowed. With both bits at 1, virtualized requests are allowed for every target except depth.
- R10: The illegal-instruction check takes priority: with the machine bit at 0, a virtualized request to a gated target gives illegal, never virtual.
- R11: While req_valid is 1, exactly one of acc_ok, acc_ill and acc_virt is high. While req_valid is 0, all three are low.
- R12: rec_upd equals xfer_qual in the same cycle under every enable setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe for the selected enable register |
| csr_sel | input | 1 | Register select: 0 machine-level, 1 hypervisor-level |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data of the selected register, masked |
| req_valid | input | 1 | An access request is present |
| req_priv | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Virtualization flag |
| req_kind | input | 3 | Target code: 0 sup ctl, 1 vsup ctl, 2 depth, 3 status, 4 indirect alias, 5 trace-clear |
| req_isel | input | 12 | Indirect-index value used with target 4 |
| acc_ok | output | 1 | Request allowed |
| acc_ill | output | 1 | Request raises illegal-instruction |
| acc_virt | output | 1 | Request raises virtual-instruction |
| xfer_qual | input | 1 | A qualifying control transfer retires |
| rec_upd | output | 1 | Implicit trace-record update strobe |

## Verification
The bench aims at the edges of the select window (0x1FF, 0x200, 0x2FF, 0x300). A design with an off-by-one compare would trap on a value outside the window or let one inside it through. It checks a guest depth access with both enables at 1: a design that handles depth like the other registers would return allowed there. It checks a guest access with the machine bit clear, where a wrong priority would return virtual instead of illegal. It also clears the machine bit and then sets it again to catch a hypervisor bit that comes back unmasked or that survives the clear.

// File: rtl/trc_perm_pkg.sv
package trc_perm_pkg;

   typedef enum logic [2:0] {
      TK_SCTL   = 3'd0,
      TK_VCTL   = 3'd1,
      TK_DEPTH  = 3'd2,
      TK_STAT   = 3'd3,
      TK_IALIAS = 3'd4,
      TK_CLEAR  = 3'd5
   } trc_kind_e;

   localparam logic [1:0] PRIV_MACHINE = 2'd3;

   typedef struct packed {
      logic gated;   // target is subject to the enable gates
      logic depth;   // target is the depth register
   } tgt_cls_t;

endpackage

// File: rtl/trc_en_regs.sv
module trc_en_regs #(
   parameter int XLEN    = 64,
   parameter int EN_BIT  = 54,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            sel,
   input  logic            wr_bit,
   output logic            m_en,
   output logic            h_en,
   output logic [XLEN-1:0] rdata
);

   initial begin
      assert (EN_BIT >= 0 && EN_BIT < XLEN)
         else $error("enable bit position outside register width");
   end

   logic m_q;
   logic h_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                m_q <= 1'b0;
      else if (wr_en && !sel)    m_q <= wr_bit;
   end

   generate
      if (HAS_HYP) begin : g_hyp
         always_ff @(posedge clk) begin
            if (!rst_n)                        h_q <= 1'b0;
            else if (wr_en && !sel && !wr_bit) h_q <= 1'b0;
            else if (wr_en && sel)             h_q <= wr_bit & m_q;
         end
      end else begin : g_nohyp
         assign h_q = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata         = '0;
      rdata[EN_BIT] = sel ? h_q : m_q;
   end

   assign m_en = m_q;
   assign h_en = h_q;

   // R3: the hypervisor bit never holds 1 while the machine bit is clear
   p_hyp_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !m_q |-> !h_q);

   // R2: a machine-register write lands on the next cycle
   p_mwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel) |=> (m_q == $past(wr_bit)));

endmodule

// File: rtl/trc_tgt_decode.sv
module trc_tgt_decode
   import trc_perm_pkg::*;
#(
   parameter int SEL_W  = 12,
   parameter int WIN_LO = 'h200,
   parameter int WIN_HI = 'h2FF
) (
   input  logic [2:0]       kind,
   input  logic [SEL_W-1:0] isel,
   output tgt_cls_t         cls
);

   localparam logic [SEL_W-1:0] LO = SEL_W'(WIN_LO);
   localparam logic [SEL_W-1:0] HI = SEL_W'(WIN_HI);

   initial begin
      assert (WIN_LO <= WIN_HI) else $error("select window is empty");
      assert (WIN_HI < (1 << SEL_W)) else $error("select window exceeds index width");
   end

   logic in_win;
   assign in_win = (isel >= LO) && (isel <= HI);

   always_comb begin
      cls = '0;
      unique case (kind)
         TK_SCTL, TK_VCTL, TK_STAT, TK_CLEAR: cls.gated = 1'b1;
         TK_DEPTH:  begin cls.gated = 1'b1; cls.depth = 1'b1; end
         TK_IALIAS: cls.gated = in_win;
         default:   cls = '0;
      endcase
   end

endmodule

// File: rtl/trc_verdict.sv
module trc_verdict
   import trc_perm_pkg::*;
#(
   parameter bit HAS_HYP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic [1:0] priv,
   input  logic       virt,
   input  tgt_cls_t   cls,
   input  logic       m_en,
   input  logic       h_en,
   output logic       ok,
   output logic       ill,
   output logic       vi
);

   logic below_m;
   logic guest;

   assign below_m = (priv != PRIV_MACHINE);
   assign guest   = HAS_HYP && virt && below_m;

   always_comb begin
      ok  = 1'b0;
      ill = 1'b0;
      vi  = 1'b0;
      if (valid) begin
         if (below_m && !m_en && cls.gated)    ill = 1'b1;
         else if (guest && cls.depth)          vi  = 1'b1;
         else if (guest && cls.gated && !h_en) vi  = 1'b1;
         else                                  ok  = 1'b1;
      end
   end

   // R11: one verdict per valid request
   p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($countones({ok, ill, vi}) == 1));

   // R11: silent when idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !(ok || ill || vi));

   // R4: machine mode never traps
   p_mmode_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && priv == PRIV_MACHINE) |-> ok);

   // R10: an illegal verdict only arises with the machine gate closed
   p_ill_moff_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ill |-> !m_en);

   // R8: guest depth access with machine gate open is a virtual trap
   p_depth_virt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && guest && cls.depth && m_en) |-> vi);

endmodule

// File: rtl/trc_perm_gate.sv
module trc_perm_gate
   import trc_perm_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int EN_BIT  = 54,
   parameter int SEL_W   = 12,
   parameter int WIN_LO  = 'h200,
   parameter int WIN_HI  = 'h2FF,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic             csr_sel,
   input  logic [XLEN-1:0]  csr_wdata,
   output logic [XLEN-1:0]  csr_rdata,
   input  logic             req_valid,
   input  logic [1:0]       req_priv,
   input  logic             req_virt,
   input  logic [2:0]       req_kind,
   input  logic [SEL_W-1:0] req_isel,
   output logic             acc_ok,
   output logic             acc_ill,
   output logic             acc_virt,
   input  logic             xfer_qual,
   output logic             rec_upd
);

   logic     m_en;
   logic     h_en;
   tgt_cls_t cls;
   logic     unused_wbits;

   assign unused_wbits = ^csr_wdata;

   trc_en_regs #(.XLEN(XLEN), .EN_BIT(EN_BIT), .HAS_HYP(HAS_HYP)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (csr_we),
      .sel    (csr_sel),
      .wr_bit (csr_wdata[EN_BIT]),
      .m_en   (m_en),
      .h_en   (h_en),
      .rdata  (csr_rdata)
   );

   trc_tgt_decode #(.SEL_W(SEL_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
      .kind (req_kind),
      .isel (req_isel),
      .cls  (cls)
   );

   trc_verdict #(.HAS_HYP(HAS_HYP)) u_vd (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (req_valid),
      .priv  (req_priv),
      .virt  (req_virt),
      .cls   (cls),
      .m_en  (m_en),
      .h_en  (h_en),
      .ok    (acc_ok),
      .ill   (acc_ill),
      .vi    (acc_virt)
   );

   // R12: recording of qualifying transfers is never gated
   assign rec_upd = xfer_qual;

   // R12: a gate closed by the machine bit still lets records through
   p_rec_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_qual && !m_en) |-> rec_upd);

endmodule

// File: tb/sim_trc_perm_gate.sv
`timescale 1ns/1ps
module sim_trc_perm_gate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_we;
   logic        csr_sel;
   logic [63:0] csr_wdata;
   logic [63:0] csr_rdata;
   logic        req_valid;
   logic [1:0]  req_priv;
   logic        req_virt;
   logic [2:0]  req_kind;
   logic [11:0] req_isel;
   logic        acc_ok, acc_ill, acc_virt;
   logic        xfer_qual, rec_upd;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   localparam logic [63:0] EN = 64'd1 << 54;
   // verdict codes: 0 none, 1 allow, 2 illegal, 3 virtual
   localparam int V_NONE = 0, V_OK = 1, V_ILL = 2, V_VI = 3;

   always #2.5 clk = ~clk;

   trc_perm_gate u0 (.*);

   task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(bit sel, logic [63:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic rd_chk(string tag, bit sel, logic [63:0] exp);
      csr_sel = sel;
      #1;
      chk64(tag, csr_rdata, exp);
   endtask

   task automatic req(string tag, logic [1:0] pv, bit vt, logic [2:0] k,
                      logic [11:0] is, int exp);
      int act;
      @(negedge clk);
      req_valid = 1'b1; req_priv = pv; req_virt = vt; req_kind = k; req_isel = is;
      #1;
      act = ({acc_ok, acc_ill, acc_virt} == 3'b100) ? V_OK :
            ({acc_ok, acc_ill, acc_virt} == 3'b010) ? V_ILL :
            ({acc_ok, acc_ill, acc_virt} == 3'b001) ? V_VI :
            ({acc_ok, acc_ill, acc_virt} == 3'b000) ? V_NONE : 9;
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: priv=%0d v=%0b kind=%0d isel=%h actual %0d expected %0d",
                  tag, pv, vt, k, is, act, exp);
      end
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk("R1 machine reg after reset", 1'b0, 64'd0);
      rd_chk("R1 hyp reg after reset", 1'b1, 64'd0);
   endtask

   task automatic t_regs;
      wr(1'b0, '1);
      rd_chk("R2 machine all-ones write", 1'b0, EN);
      wr(1'b1, '1);
      rd_chk("R2 hyp all-ones write", 1'b1, EN);
      wr(1'b0, ~EN);
      rd_chk("R2 machine bit cleared by others-only write", 1'b0, 64'd0);
      rd_chk("R3 hyp masked after machine clear", 1'b1, 64'd0);
      wr(1'b1, EN);
      rd_chk("R3 hyp cannot set with machine 0", 1'b1, 64'd0);
      wr(1'b0, EN);
      rd_chk("R3 hyp stays 0 after machine re-enable", 1'b1, 64'd0);
      wr(1'b0, 64'd0);
   endtask

   task automatic t_mmode;
      req("R4 M ctl gates off", 2'd3, 1'b0, 3'd0, 12'h0, V_OK);
      req("R4 M depth gates off", 2'd3, 1'b1, 3'd2, 12'h0, V_OK);
      req("R4 M clear gates off", 2'd3, 1'b0, 3'd5, 12'h0, V_OK);
   endtask

   task automatic t_machine_off;
      for (int k = 0; k < 6; k++)
         if (k != 4) req("R5 S machine off", 2'd1, 1'b0, 3'(k), 12'h0, V_ILL);
      req("R5 U status machine off", 2'd0, 1'b0, 3'd3, 12'h0, V_ILL);
   endtask

   task automatic t_indirect;
      req("R6 isel 0x1FF allowed", 2'd1, 1'b0, 3'd4, 12'h1FF, V_OK);
      req("R6 isel 0x200 illegal", 2'd1, 1'b0, 3'd4, 12'h200, V_ILL);
      req("R6 isel 0x2FF illegal", 2'd1, 1'b0, 3'd4, 12'h2FF, V_ILL);
      req("R6 isel 0x300 allowed", 2'd1, 1'b0, 3'd4, 12'h300, V_OK);
   endtask

   task automatic t_priority;
      req("R10 guest ctl machine off", 2'd1, 1'b1, 3'd0, 12'h0, V_ILL);
      req("R10 guest depth machine off", 2'd1, 1'b1, 3'd2, 12'h0, V_ILL);
   endtask

   task automatic t_virt;
      wr(1'b0, EN);
      req("R7 guest sctl", 2'd1, 1'b1, 3'd0, 12'h0, V_VI);
      req("R7 guest vctl", 2'd1, 1'b1, 3'd1, 12'h0, V_VI);
      req("R7 guest status", 2'd1, 1'b1, 3'd3, 12'h0, V_VI);
      req("R7 guest clear", 2'd0, 1'b1, 3'd5, 12'h0, V_VI);
      req("R7 guest alias in window", 2'd1, 1'b1, 3'd4, 12'h250, V_VI);
      req("R6 guest alias out of window", 2'd1, 1'b1, 3'd4, 12'h100, V_OK);
      req("R8 guest depth hyp off", 2'd1, 1'b1, 3'd2, 12'h0, V_VI);
      for (int k = 0; k < 6; k++)
         req("R9 host machine on", 2'd1, 1'b0, 3'(k), 12'h200, V_OK);
      wr(1'b1, EN);
      req("R9 guest sctl both on", 2'd1, 1'b1, 3'd0, 12'h0, V_OK);
      req("R9 guest status both on", 2'd1, 1'b1, 3'd3, 12'h0, V_OK);
      req("R9 guest clear both on", 2'd1, 1'b1, 3'd5, 12'h0, V_OK);
      req("R9 guest alias both on", 2'd1, 1'b1, 3'd4, 12'h2FF, V_OK);
      req("R8 guest depth both on", 2'd1, 1'b1, 3'd2, 12'h0, V_VI);
   endtask

   task automatic t_idle;
      @(negedge clk);
      req_valid = 1'b0; req_priv = 2'd1; req_virt = 1'b1; req_kind = 3'd2;
      #1;
      chk64("R11 idle outputs low", {61'd0, acc_ok, acc_ill, acc_virt}, 64'd0);
   endtask

   task automatic t_record;
      wr(1'b0, 64'd0);
      @(negedge clk); xfer_qual = 1'b1; #1;
      chk64("R12 record with enables off", {63'd0, rec_upd}, 64'd1);
      xfer_qual = 1'b0; #1;
      chk64("R12 no record without transfer", {63'd0, rec_upd}, 64'd0);
   endtask

   initial begin
      rst_n = 1'b0; csr_we = 0; csr_sel = 0; csr_wdata = '0;
      req_valid = 0; req_priv = 0; req_virt = 0; req_kind = 0; req_isel = 0;
      xfer_qual = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regs;
      t_mmode;
      t_machine_off;
      t_indirect;
      t_priority;
      t_virt;
      t_idle;
      t_record;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule